// File: doc/BRIEF.md
# FPU context save/restore controller

This block keeps the context of a floating-point unit. The context is one of three states: empty after reset, idle, or holding a pending exception. It also holds the control register, the status register, the address of the last executed instruction, a 64-bit exception operand with its 3-bit cause, and one "holds NaN" flag for each data register. Two strobes report to the block: one for every executed floating-point instruction other than a save, and one for every raised exception, which comes with its cause and operand.

On a save request the block sends the context out as a frame of four 32-bit words over a valid/ready port, and then clears the control register. On a restore request it takes in four words over a second valid/ready port. It checks the header word, then either rebuilds the context from the frame or rejects the frame. While either transfer runs, the block raises `busy` and ignores both strobes. The source is expected to hold its strobes until `busy` falls.

Top module: `fpu_ctx_ctrl`

## Requirements
- R1: After reset, `ctxState` is 0 (empty). The encodings are 0 = empty, 1 = idle and 2 = exception. `ctrlReg`, `statusReg` and `instAddrReg` read zero, every `nanFlags` bit is 1, and `busy` and `fmtErr` are 0.
- R2: An instruction strobe accepted while not busy has three effects one edge later. It moves the empty state to idle, it loads `instAddrReg` from `instAddr`, and it clears the `nanFlags` bit selected by `instDst`. The idle and exception states are left as they are.
- R3: An exception strobe accepted while not busy moves the state to exception one edge later. It captures the 3-bit `excCause` as the frame vector and `excOperand` as the operand. If both strobes arrive in the same cycle, the exception decides the state and the instruction still updates the address and the flag.
- R4: A save sends exactly four words, with index 0, 1, 2, 3 on `saveIdx`. The word layout is:
  - word 0: bits 31:24 format, bits 23:19 zero, bits 18:16 vector, bits 15:0 control register;
  - word 1: operand bits 63:32;
  - word 2: operand bits 31:0;
  - word 3: status register.
- R5: The format byte is 0x00 in the empty state, 0x05 in the idle state and 0xE5 in the exception state. Outside the exception state, the vector field and both operand words are sent as zero.
- R6: The handshake of word 3 ends the save. One edge after it, `busy` is low and `ctrlReg` is zero, while the status register and the state are kept.
- R7: A restore with format 0x05 or 0xE5 loads the control register from word 0 bits 15:0 and the status register from word 3, and sets the state to idle or to exception. For 0xE5 it also loads the vector from word 0 bits 18:16 and the operand from words 1 and 2. For 0x05 the vector and operand become zero.
- R8: A restore with format 0x00 returns the block to its reset context: state empty, all registers zero and all NaN flags set.
- R9: A restore whose format byte is not 0x00, 0x05 or 0xE5, or whose word 0 bits 23:19 are not all zero, sets `fmtErr` and leaves the state and all registers unchanged. `fmtErr` stays set until the next restore starts.
- R10: From the cycle after a save or restore request until the last word's handshake, `busy` is high and both strobes are ignored.
- R11: While `saveValid` is high and `saveReady` is low, the word index and the word on `saveData` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instStrobe | input | 1 | An instruction other than a save executed |
| instAddr | input | ADDR_W | Address of that instruction |
| instDst | input | clog2(NREG) | Data register written by that instruction |
| excStrobe | input | 1 | An exception was raised |
| excCause | input | 3 | Cause code of the exception |
| excOperand | input | 64 | Operand of the exception |
| busy | output | 1 | Transfer in progress; strobes are ignored |
| saveReq | input | 1 | Start a save |
| saveReady | input | 1 | Consumer takes the current save word |
| saveValid | output | 1 | Save word valid |
| saveIdx | output | 2 | Index of the current save word |
| saveData | output | 32 | Current save word |
| restoreReq | input | 1 | Start a restore |
| rstrValid | input | 1 | Producer offers a restore word |
| rstrData | input | 32 | Restore word |
| rstrReady | output | 1 | Block accepts a restore word |
| rstrIdx | output | 2 | Index expected for the next restore word |
| ctxState | output | 2 | Context state: 0 empty, 1 idle, 2 exception |
| fmtErr | output | 1 | Last restore frame was rejected |
| ctrlReg | output | 16 | Control register |
| statusReg | output | 32 | Status register |
| instAddrReg | output | ADDR_W | Instruction address register |
| nanFlags | output | NREG | One bit per data register, set when it holds NaN |

## Verification
Strobe effects and restore results are registered, so each one appears one edge after the cycle that accepted it. The bench therefore sets inputs and reads outputs on falling edges, one full cycle apart. A save word is valid from the falling edge after the request, and each following word is due one cycle after the previous handshake. The cleared control register and the dropped `busy` are due one edge after the word-3 handshake. The bench compares each word at the falling edge where that index is shown, and reads the end-of-transfer state at the next falling edge. Stall and ignore behaviour is checked by holding `saveReady` low for several cycles. During that stall the bench fires strobes, then inspects the frame and registers that follow.

// File: rtl/fpu_ctx_pkg.sv
package fpu_ctx_pkg;

  localparam int WORD_W = 32;
  localparam int FRAME_WORDS = 4;
  localparam int IDX_W = $clog2(FRAME_WORDS);

  localparam logic [7:0] FMT_NULL = 8'h00;
  localparam logic [7:0] FMT_IDLE = 8'h05;
  localparam logic [7:0] FMT_EXCP = 8'hE5;

  typedef enum logic [1:0] {
    CTX_NULL = 2'd0,
    CTX_IDLE = 2'd1,
    CTX_EXCP = 2'd2
  } ctxStateT;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SAVE = 2'd1,
    PH_RSTR = 2'd2
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic instUpd;  // accepted instruction: address and NaN flag
    logic excUpd;   // accepted exception: cause and operand
    logic bufWr;    // store restore word 0..2
    logic clrCtrl;  // save finished: clear control register
    logic rstNull;  // restored empty frame
    logic ldIdle;   // restored idle frame
    logic ldExcp;   // restored exception frame
  } dpStrobeT;

endpackage

// File: rtl/fpu_ctx_fsm.sv
module fpu_ctx_fsm
  import fpu_ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instStrobe,
  input  logic              excStrobe,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic              saveReady,
  input  logic              rstrValid,
  input  logic [7:0]        bufFmt,
  input  logic [4:0]        bufPad,
  output ctxStateT          ctxState,
  output logic              busy,
  output logic              saveValid,
  output logic              rstrReady,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              fmtErr,
  output dpStrobeT          dpStb
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  phaseT    phase;
  ctxStateT ctxNext;
  logic     saveFire, rstrFire, lastWord, commit, fmtOk;

  assign busy      = (phase != PH_IDLE);
  assign saveValid = (phase == PH_SAVE);
  assign rstrReady = (phase == PH_RSTR);
  assign saveFire  = saveValid && saveReady;
  assign rstrFire  = rstrReady && rstrValid;
  assign lastWord  = (wordIdx == LAST_IDX);
  assign commit    = rstrFire && lastWord;
  assign fmtOk     = (bufPad == 5'd0) &&
                     ((bufFmt == FMT_NULL) || (bufFmt == FMT_IDLE) || (bufFmt == FMT_EXCP));

  always_comb begin
    dpStb         = '0;
    dpStb.instUpd = !busy && instStrobe;
    dpStb.excUpd  = !busy && excStrobe;
    dpStb.bufWr   = rstrFire && !lastWord;
    dpStb.clrCtrl = saveFire && lastWord;
    dpStb.rstNull = commit && fmtOk && (bufFmt == FMT_NULL);
    dpStb.ldIdle  = commit && fmtOk && (bufFmt == FMT_IDLE);
    dpStb.ldExcp  = commit && fmtOk && (bufFmt == FMT_EXCP);
  end

  always_comb begin
    ctxNext = ctxState;
    if (dpStb.excUpd)                                ctxNext = CTX_EXCP;
    else if (dpStb.instUpd && ctxState == CTX_NULL)  ctxNext = CTX_IDLE;
    if (dpStb.rstNull)     ctxNext = CTX_NULL;
    else if (dpStb.ldIdle) ctxNext = CTX_IDLE;
    else if (dpStb.ldExcp) ctxNext = CTX_EXCP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      wordIdx  <= '0;
      ctxState <= CTX_NULL;
      fmtErr   <= 1'b0;
    end else begin
      ctxState <= ctxNext;
      case (phase)
        PH_IDLE: begin
          wordIdx <= '0;
          if (saveReq) phase <= PH_SAVE;
          else if (restoreReq) begin
            phase  <= PH_RSTR;
            fmtErr <= 1'b0;
          end
        end
        PH_SAVE: if (saveFire) begin
          wordIdx <= wordIdx + 1'b1;
          if (lastWord) phase <= PH_IDLE;
        end
        PH_RSTR: if (rstrFire) begin
          wordIdx <= wordIdx + 1'b1;
          if (lastWord) begin
            phase  <= PH_IDLE;
            fmtErr <= !fmtOk;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_null_to_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    instStrobe && !excStrobe && !busy && ctxState == CTX_NULL |=> ctxState == CTX_IDLE);

  p_exc_enters_r3: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe && !busy |=> ctxState == CTX_EXCP);

  p_save_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    saveValid && saveReady && wordIdx == LAST_IDX |=> !busy);

  p_bad_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    commit && !fmtOk |=> fmtErr && $stable(ctxState));

  p_save_keeps_ctx_r10: assert property (@(posedge clk) disable iff (!rstN)
    saveValid |=> $stable(ctxState));

  p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    saveValid && !saveReady |=> saveValid && $stable(wordIdx));

endmodule

// File: rtl/fpu_ctx_dp.sv
module fpu_ctx_dp
  import fpu_ctx_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 32,
  localparam int DST_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          stb,
  input  ctxStateT          ctxState,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [DST_W-1:0]  instDst,
  input  logic [2:0]        excCause,
  input  logic [63:0]       excOperand,
  input  logic [WORD_W-1:0] rstrData,
  output logic [WORD_W-1:0] saveData,
  output logic [7:0]        bufFmt,
  output logic [4:0]        bufPad,
  output logic [15:0]       ctrlReg,
  output logic [31:0]       statusReg,
  output logic [ADDR_W-1:0] addrReg,
  output logic [NREG-1:0]   nanFlags
);

  logic [63:0]       operandReg;
  logic [2:0]        vectorReg;
  logic [WORD_W-1:0] rxBuf [FRAME_WORDS-1];
  logic [7:0]        fmtByte;
  logic              isExcp;

  assign bufFmt = rxBuf[0][31:24];
  assign bufPad = rxBuf[0][23:19];
  assign isExcp = (ctxState == CTX_EXCP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FRAME_WORDS - 1; i++) rxBuf[i] <= '0;
    end else if (stb.bufWr) begin
      rxBuf[wordIdx] <= rstrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.rstNull) begin
      ctrlReg    <= '0;
      statusReg  <= '0;
      addrReg    <= '0;
      operandReg <= '0;
      vectorReg  <= '0;
      nanFlags   <= '1;
    end else begin
      if (stb.instUpd) begin
        addrReg           <= instAddr;
        nanFlags[instDst] <= 1'b0;
      end
      if (stb.excUpd) begin
        vectorReg  <= excCause;
        operandReg <= excOperand;
      end
      if (stb.clrCtrl) ctrlReg <= '0;
      if (stb.ldIdle || stb.ldExcp) begin
        ctrlReg   <= rxBuf[0][15:0];
        statusReg <= rstrData;
        vectorReg  <= stb.ldExcp ? rxBuf[0][18:16] : 3'd0;
        operandReg <= stb.ldExcp ? {rxBuf[1], rxBuf[2]} : 64'd0;
      end
    end
  end

  always_comb begin
    case (ctxState)
      CTX_IDLE: fmtByte = FMT_IDLE;
      CTX_EXCP: fmtByte = FMT_EXCP;
      default:  fmtByte = FMT_NULL;
    endcase
    case (wordIdx)
      2'd0:    saveData = {fmtByte, 5'd0, isExcp ? vectorReg : 3'd0, ctrlReg};
      2'd1:    saveData = isExcp ? operandReg[63:32] : '0;
      2'd2:    saveData = isExcp ? operandReg[31:0] : '0;
      default: saveData = statusReg;
    endcase
  end

  p_ctrl_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrCtrl |=> ctrlReg == 16'd0);

  p_null_restore_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.rstNull |=> (&nanFlags) && statusReg == 32'd0 && addrReg == '0);

  p_null_regs_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctxState == CTX_NULL |-> ctrlReg == 16'd0 && statusReg == 32'd0);

endmodule

// File: rtl/fpu_ctx_ctrl.sv
module fpu_ctx_ctrl
  import fpu_ctx_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 32,
  localparam int DST_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instStrobe,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [DST_W-1:0]  instDst,
  input  logic              excStrobe,
  input  logic [2:0]        excCause,
  input  logic [63:0]       excOperand,
  output logic              busy,
  input  logic              saveReq,
  input  logic              saveReady,
  output logic              saveValid,
  output logic [1:0]        saveIdx,
  output logic [31:0]       saveData,
  input  logic              restoreReq,
  input  logic              rstrValid,
  input  logic [31:0]       rstrData,
  output logic              rstrReady,
  output logic [1:0]        rstrIdx,
  output logic [1:0]        ctxState,
  output logic              fmtErr,
  output logic [15:0]       ctrlReg,
  output logic [31:0]       statusReg,
  output logic [ADDR_W-1:0] instAddrReg,
  output logic [NREG-1:0]   nanFlags
);

  ctxStateT         ctxInt;
  dpStrobeT         dpStb;
  logic [IDX_W-1:0] wordIdx;
  logic [7:0]       bufFmt;
  logic [4:0]       bufPad;

  assign ctxState = ctxInt;
  assign saveIdx  = wordIdx;
  assign rstrIdx  = wordIdx;

  fpu_ctx_fsm u_fsm (
    .clk(clk), .rstN(rstN),
    .instStrobe(instStrobe), .excStrobe(excStrobe),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .saveReady(saveReady), .rstrValid(rstrValid),
    .bufFmt(bufFmt), .bufPad(bufPad),
    .ctxState(ctxInt), .busy(busy),
    .saveValid(saveValid), .rstrReady(rstrReady),
    .wordIdx(wordIdx), .fmtErr(fmtErr), .dpStb(dpStb)
  );

  fpu_ctx_dp #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(dpStb), .ctxState(ctxInt),
    .wordIdx(wordIdx), .instAddr(instAddr), .instDst(instDst),
    .excCause(excCause), .excOperand(excOperand), .rstrData(rstrData),
    .saveData(saveData), .bufFmt(bufFmt), .bufPad(bufPad),
    .ctrlReg(ctrlReg), .statusReg(statusReg),
    .addrReg(instAddrReg), .nanFlags(nanFlags)
  );

endmodule

// File: tb/fpu_ctx_ctrl_test.sv
module fpu_ctx_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instStrobe = 1'b0;
  logic [31:0] instAddr = '0;
  logic [2:0]  instDst = '0;
  logic        excStrobe = 1'b0;
  logic [2:0]  excCause = '0;
  logic [63:0] excOperand = '0;
  logic        busy, saveValid, rstrReady, fmtErr;
  logic        saveReq = 1'b0, saveReady = 1'b0;
  logic        restoreReq = 1'b0, rstrValid = 1'b0;
  logic [31:0] rstrData = '0;
  logic [1:0]  saveIdx, rstrIdx, ctxState;
  logic [31:0] saveData, statusReg, instAddrReg;
  logic [15:0] ctrlReg;
  logic [7:0]  nanFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpu_ctx_ctrl uut (
    .clk(clk), .rstN(rstN),
    .instStrobe(instStrobe), .instAddr(instAddr), .instDst(instDst),
    .excStrobe(excStrobe), .excCause(excCause), .excOperand(excOperand),
    .busy(busy), .saveReq(saveReq), .saveReady(saveReady),
    .saveValid(saveValid), .saveIdx(saveIdx), .saveData(saveData),
    .restoreReq(restoreReq), .rstrValid(rstrValid), .rstrData(rstrData),
    .rstrReady(rstrReady), .rstrIdx(rstrIdx), .ctxState(ctxState),
    .fmtErr(fmtErr), .ctrlReg(ctrlReg), .statusReg(statusReg),
    .instAddrReg(instAddrReg), .nanFlags(nanFlags)
  );

  // frame words {w0,w1,w2,w3}, and whether the frame must be rejected
  localparam logic [127:0] FRAMES [7] = '{
    {32'h05001234, 32'h11111111, 32'h22222222, 32'hAABB0001},
    {32'hE5031F00, 32'hDEADBEEF, 32'h01234567, 32'h00000080},
    {32'hE507FFFF, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h0000FFFF},
    {32'h07000000, 32'h0,        32'h0,        32'h0},
    {32'hE5080000, 32'h0,        32'h0,        32'h0},
    {32'h00000000, 32'h0,        32'h0,        32'h0},
    {32'h05008001, 32'h0,        32'h0,        32'h12345678}
  };
  localparam bit BAD [7] = '{0, 0, 0, 1, 1, 0, 0};

  // requirement-level model of the context
  logic [1:0]  mCtx;
  logic [15:0] mCtrl;
  logic [31:0] mStatus;
  logic [2:0]  mVec;
  logic [63:0] mOp;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int k);
    logic [7:0] f;
    f = (mCtx == 2'd2) ? 8'hE5 : (mCtx == 2'd1) ? 8'h05 : 8'h00;
    case (k)
      0: return {f, 5'd0, (mCtx == 2'd2) ? mVec : 3'd0, mCtrl};
      1: return (mCtx == 2'd2) ? mOp[63:32] : 32'd0;
      2: return (mCtx == 2'd2) ? mOp[31:0] : 32'd0;
      default: return mStatus;
    endcase
  endfunction

  // issue saveReq, optionally stall on word 0, then drain four words
  task automatic doSave(input int stall, input bit strobeInStall);
    @(negedge clk) saveReq = 1'b1;
    @(negedge clk) saveReq = 1'b0;
    check(busy, "R10 busy in save", 64'(busy), 64'd1);
    for (int s = 0; s < stall; s++) begin
      check(saveIdx == 2'd0 && saveData == expWord(0), "R11 stall holds word",
            64'(saveData), 64'(expWord(0)));
      if (strobeInStall && s == 0) begin
        instStrobe = 1'b1; instAddr = 32'h3000; instDst = 3'd1;
        excStrobe = 1'b1; excCause = 3'd1; excOperand = 64'h1;
      end else begin
        instStrobe = 1'b0; excStrobe = 1'b0;
      end
      @(negedge clk);
    end
    instStrobe = 1'b0; excStrobe = 1'b0;
    saveReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check(saveValid && saveIdx == 2'(k), "R4 word index", {62'd0, saveIdx}, 64'(k));
      check(saveData == expWord(k), "R4 R5 frame word", 64'(saveData), 64'(expWord(k)));
      @(negedge clk);
    end
    saveReady = 1'b0;
    mCtrl = '0;
    check(!busy, "R6 save done", 64'(busy), 64'd0);
    check(ctrlReg == 16'd0, "R6 control cleared", 64'(ctrlReg), 64'd0);
    check(statusReg == mStatus && ctxState == mCtx, "R6 status and state kept",
          {ctxState, statusReg}, {mCtx, mStatus});
  endtask

  task automatic doRestore(input logic [127:0] fr);
    @(negedge clk) restoreReq = 1'b1;
    @(negedge clk) restoreReq = 1'b0;
    rstrValid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rstrData = fr[127 - 32*k -: 32];
      check(rstrReady && rstrIdx == 2'(k), "R10 restore index", {62'd0, rstrIdx}, 64'(k));
      @(negedge clk);
    end
    rstrValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mCtx = 2'd0; mCtrl = '0; mStatus = '0; mVec = '0; mOp = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctxState == 2'd0, "R1 state empty", 64'(ctxState), 64'd0);
    check(ctrlReg == 0 && statusReg == 0 && instAddrReg == 0, "R1 regs zero",
          {ctrlReg, statusReg[15:0], instAddrReg[15:0]}, 64'd0);
    check(nanFlags == 8'hFF, "R1 NaN flags", 64'(nanFlags), 64'hFF);
    check(!busy && !fmtErr, "R1 busy/fmtErr low", {62'd0, busy, fmtErr}, 64'd0);

    // R2 instruction leaves empty state
    instStrobe = 1'b1; instAddr = 32'h1000; instDst = 3'd3;
    @(negedge clk) instStrobe = 1'b0;
    check(ctxState == 2'd1, "R2 empty to idle", 64'(ctxState), 64'd1);
    check(instAddrReg == 32'h1000, "R2 address", 64'(instAddrReg), 64'h1000);
    check(nanFlags == 8'hF7, "R2 NaN flag cleared", 64'(nanFlags), 64'hF7);
    mCtx = 2'd1;
    doSave(0, 1'b0);

    // R3 exception and instruction in one cycle
    excStrobe = 1'b1; excCause = 3'd5; excOperand = 64'hCAFEF00D_12345678;
    instStrobe = 1'b1; instAddr = 32'h2000; instDst = 3'd0;
    @(negedge clk) begin excStrobe = 1'b0; instStrobe = 1'b0; end
    check(ctxState == 2'd2, "R3 exception state", 64'(ctxState), 64'd2);
    check(instAddrReg == 32'h2000 && nanFlags == 8'hF6, "R3 instruction also applied",
          {instAddrReg, 24'd0, nanFlags}, {32'h2000, 24'd0, 8'hF6});
    mCtx = 2'd2; mVec = 3'd5; mOp = 64'hCAFEF00D_12345678;

    // R10 R11 stall with strobes ignored while busy
    doSave(3, 1'b1);
    check(instAddrReg == 32'h2000 && nanFlags == 8'hF6, "R10 strobes ignored",
          {instAddrReg, 24'd0, nanFlags}, {32'h2000, 24'd0, 8'hF6});
    doSave(0, 1'b0);  // vector and operand unchanged by ignored exception

    // table of restore frames
    for (int e = 0; e < 7; e++) begin
      logic [127:0] fr;
      fr = FRAMES[e];
      doRestore(fr);
      if (!BAD[e]) begin
        case (fr[127:120])
          8'h00: begin mCtx = 2'd0; mCtrl = '0; mStatus = '0; mVec = '0; mOp = '0; end
          8'h05: begin mCtx = 2'd1; mCtrl = fr[111:96]; mStatus = fr[31:0]; mVec = '0; mOp = '0; end
          default: begin mCtx = 2'd2; mCtrl = fr[111:96]; mStatus = fr[31:0];
                         mVec = fr[114:112]; mOp = fr[95:32]; end
        endcase
      end
      check(fmtErr == BAD[e], "R9 format error flag", 64'(fmtErr), 64'(BAD[e]));
      check(ctxState == mCtx, "R7 R9 state after restore", 64'(ctxState), 64'(mCtx));
      check(ctrlReg == mCtrl && statusReg == mStatus, "R7 R9 regs after restore",
            {ctrlReg, statusReg}, {mCtrl, mStatus});
      if (!BAD[e] && fr[127:120] == 8'h00)
        check(nanFlags == 8'hFF && instAddrReg == 0, "R8 empty frame resets",
              {instAddrReg, 24'd0, nanFlags}, 64'hFF);
      doSave(0, 1'b0);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule